// File: doc/BRIEF.md
# Prescaled PWM Channel with Synchronised Duty Update

This block is one pulse-width modulation channel with a byte-wide register interface. A clock-select field picks one of three reference tick inputs, or none. The chosen tick stream passes through a pre-divider with a ratio of 1, 3, 5 or 6 and then through a power-of-two stage of 2^0 to 2^7. Each resulting divided tick advances a 9-bit period counter. The output is high while that counter is below the active duty value.

Software writes the duty value and the clock settings into shadow registers. They take effect only when bit 0 of the sync register is written. If the glitch-removal bit is set, the transfer waits for the end of the running period. If it is clear, the transfer happens at once. When a committed change alters the clock settings, the dividers and the period counter restart, so the new period begins cleanly. Reference ticks arrive as single-cycle enable pulses from clock generation outside the block.

Top module: `pwm_sync_channel`

## Requirements
- R1: A synchronous active-high reset clears every register: reads of 0x41 and 0x46 return 0, `pwm_out` is low and `pwm_oe` is low.
- R2: Reads of 0x41, 0x42, 0x43, 0x44, 0x45 and 0x46 return the last byte written to them. 0x05 always reads 0x0B. The sync register 0x47 and every unmapped address read 0.
- R3: Writes to the duty pair (low byte at 0x44, high byte at 0x45) and to the clock fields have no effect on the output until bit 0 is written as 1 at address 0x47.
- R4: With the clock running, each 512-tick period holds exactly min(duty, 512) high ticks. A duty of 0 gives a constant low output, and a duty of 512 or more gives a constant high output.
- R5: The period lasts 512 × P × 2^E selected reference ticks. E is bits [2:0] of 0x42. P is chosen by bits [6:5] of 0x42: code 0 gives 1, 1 gives 3, 2 gives 5 and 3 gives 6.
- R6: Bits [1:0] of 0x41 select the reference: code 1 selects `ref_tick[0]`, 2 selects `ref_tick[1]` and 3 selects `ref_tick[2]`. Code 0 freezes the counter, so the output stays static.
- R7: With bit 5 of 0x43 set, a sync commit waits until the period counter wraps from 511 to 0. With that bit clear, the new values act from the cycle after the sync write.
- R8: While the active clock select is 0, a sync commit in glitch-removal mode takes effect at once, because no period boundary can occur.
- R9: The output can be high only when bit 7 (drive enable) and bit 2 (PWM source) of 0x46 are both set; otherwise it is low. Bit 1 (ramp source) does not drive the output. Bit 5 of 0x46 appears directly on `pwm_oe`.
- R10: A commit that changes any clock field restarts both dividers and resets the period counter to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| ref_tick | input | NREF (3) | Reference clock enable pulses |
| pwm_out | output | 1 | Modulated output |
| pwm_oe | output | 1 | Output buffer drive enable |

## Verification
The bench measures duty at the extremes: 0, 1, 511, exactly 512 and 0xFFFF. A design that compared only the low 9 bits would wrap 512 and 0xFFFF into short pulses. It times full periods for several pre-divider and exponent combinations, which exposes a wrong entry in the ratio mapping or an off-by-one in the exponent counter. For glitch-removal mode, the bench places a sync write in the middle of a period and checks the output both before and after the wrap. An immediate commit would drive the output high too early, and a lost pending flag would leave it low. Two further checks cover clock changes. An idle clock select must still let a pending commit land. A changed prescale must restart the counter, because a design that failed to restart would keep the old phase and stay low.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

    localparam logic [7:0] A_SUBTYPE = 8'h05;
    localparam logic [7:0] A_SIZE    = 8'h41;
    localparam logic [7:0] A_PDIV    = 8'h42;
    localparam logic [7:0] A_TCFG    = 8'h43;
    localparam logic [7:0] A_DUTY_LO = 8'h44;
    localparam logic [7:0] A_DUTY_HI = 8'h45;
    localparam logic [7:0] A_ECTL    = 8'h46;
    localparam logic [7:0] A_SYNC    = 8'h47;

    localparam logic [7:0] SUBTYPE_ID = 8'h0B;
    localparam int EXP_W  = 3;
    localparam int DUTY_W = 16;

    typedef struct packed {
        logic [1:0]       sel;
        logic [1:0]       pdiv;
        logic [EXP_W-1:0] expo;
    } clk_cfg_t;

    typedef struct packed {
        clk_cfg_t          clk;
        logic [DUTY_W-1:0] duty;
    } pwm_cfg_t;

    typedef struct packed {
        logic drive;
        logic oe;
        logic src_pwm;
        logic src_ramp;
    } out_ctl_t;

    function automatic logic [2:0] pdiv_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd3;
            2'd2:    return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       boundary,
    output pwm_cfg_t   act,
    output logic       restart,
    output logic       pend,
    output out_ctl_t   ctl
);

    logic [7:0] r_size, r_pdiv, r_tcfg, r_dlo, r_dhi, r_ectl;
    pwm_cfg_t   shadow;
    logic       sync_wr, glitch, idle, commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_size <= '0;
            r_pdiv <= '0;
            r_tcfg <= '0;
            r_dlo  <= '0;
            r_dhi  <= '0;
            r_ectl <= '0;
        end else if (wr_en) begin
            case (addr)
                A_SIZE:    r_size <= wdata;
                A_PDIV:    r_pdiv <= wdata;
                A_TCFG:    r_tcfg <= wdata;
                A_DUTY_LO: r_dlo  <= wdata;
                A_DUTY_HI: r_dhi  <= wdata;
                A_ECTL:    r_ectl <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        shadow.clk.sel  = r_size[1:0];
        shadow.clk.pdiv = r_pdiv[6:5];
        shadow.clk.expo = r_pdiv[EXP_W-1:0];
        shadow.duty     = {r_dhi, r_dlo};
    end

    assign sync_wr = wr_en && (addr == A_SYNC) && wdata[0];
    assign glitch  = r_tcfg[5];
    assign idle    = (act.clk.sel == 2'd0);
    // A deferred commit needs a boundary, which never comes on an idle clock.
    assign commit  = (sync_wr && (!glitch || idle)) || (pend && (boundary || idle));
    assign restart = commit && (shadow.clk != act.clk);

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= '0;
            pend <= 1'b0;
        end else begin
            if (commit) act <= shadow;
            if (commit)       pend <= 1'b0;
            else if (sync_wr) pend <= 1'b1;
        end
    end

    always_comb begin
        ctl.drive    = r_ectl[7];
        ctl.oe       = r_ectl[5];
        ctl.src_pwm  = r_ectl[2];
        ctl.src_ramp = r_ectl[1];
    end

    always_comb begin
        case (addr)
            A_SUBTYPE: rdata = SUBTYPE_ID;
            A_SIZE:    rdata = r_size;
            A_PDIV:    rdata = r_pdiv;
            A_TCFG:    rdata = r_tcfg;
            A_DUTY_LO: rdata = r_dlo;
            A_DUTY_HI: rdata = r_dhi;
            A_ECTL:    rdata = r_ectl;
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_sync_pkg::*;
#(
    parameter int NREF = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic [NREF-1:0] ref_tick,
    input  clk_cfg_t        cfg,
    output logic            div_tick
);

    localparam int ECNT_W = (1 << EXP_W) - 1;

    logic [NREF:0]       tick_ext;
    logic                src;
    logic [2:0]          pre_cnt;
    logic [2:0]          pre_lim;
    logic [ECNT_W-1:0]   exp_cnt;
    logic [ECNT_W-1:0]   exp_lim;

    // Slot 0 stands for "no clock" and never ticks.
    assign tick_ext = {ref_tick, 1'b0};
    assign src      = tick_ext[cfg.sel];
    assign pre_lim  = pdiv_ratio(cfg.pdiv) - 3'd1;
    assign exp_lim  = (ECNT_W'(1) << cfg.expo) - ECNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt  <= '0;
            exp_cnt  <= '0;
            div_tick <= 1'b0;
        end else begin
            div_tick <= 1'b0;
            if (src) begin
                if (pre_cnt == pre_lim) begin
                    pre_cnt <= '0;
                    if (exp_cnt == exp_lim) begin
                        exp_cnt  <= '0;
                        div_tick <= 1'b1;
                    end else begin
                        exp_cnt <= exp_cnt + 1'b1;
                    end
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pwm_period.sv
module pwm_period
    import pwm_sync_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              div_tick,
    input  logic [DUTY_W-1:0] duty,
    input  logic              gate,
    output logic [CNT_W-1:0]  cnt,
    output logic              boundary,
    output logic              pwm_out
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (div_tick)  cnt <= cnt + 1'b1;
    end

    assign boundary = div_tick && (cnt == CNT_MAX);
    // Duty is wider than the count, so values of 2^CNT_W or more stay high.
    assign pwm_out  = gate && (DUTY_W'(cnt) < duty);

endmodule

// File: rtl/pwm_sync_channel.sv
module pwm_sync_channel
    import pwm_sync_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int NREF  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [7:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic [NREF-1:0] ref_tick,
    output logic            pwm_out,
    output logic            pwm_oe
);

    pwm_cfg_t          act_cfg;
    out_ctl_t          ctl;
    logic              restart, pend, boundary, div_tick;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        act_sel;
    logic [DUTY_W-1:0] act_duty;

    assign act_sel  = act_cfg.clk.sel;
    assign act_duty = act_cfg.duty;
    assign pwm_oe   = ctl.oe;

    pwm_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .boundary (boundary),
        .act      (act_cfg),
        .restart  (restart),
        .pend     (pend),
        .ctl      (ctl)
    );

    pwm_prescaler #(.NREF(NREF)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .ref_tick (ref_tick),
        .cfg      (act_cfg.clk),
        .div_tick (div_tick)
    );

    pwm_period #(.CNT_W(CNT_W)) u_per (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .div_tick (div_tick),
        .duty     (act_duty),
        .gate     (ctl.drive && ctl.src_pwm),
        .cnt      (cnt),
        .boundary (boundary),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm_sync_chk.sv
module pwm_sync_chk
    import pwm_sync_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        addr,
    input logic [7:0]        rdata,
    input logic              pwm_out,
    input logic              pwm_oe,
    input logic              pend,
    input logic              boundary,
    input logic [1:0]        act_sel,
    input logic [DUTY_W-1:0] act_duty,
    input logic              restart,
    input logic [CNT_W-1:0]  cnt,
    input logic [7:0]        ectl
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwm_out && !pwm_oe)); // R1

    AST_SUBTYPE_CONST: assert property (@(posedge clk) disable iff (rst)
        (addr == A_SUBTYPE) |-> (rdata == SUBTYPE_ID)); // R2

    AST_SYNC_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr == A_SYNC) |-> (rdata == 8'h00)); // R2

    AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (act_duty == '0) |-> !pwm_out); // R4

    AST_GLITCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend && !boundary && (act_sel != 2'd0)) |=> $stable(act_duty)); // R7

    AST_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!ectl[7] || !ectl[2]) |-> !pwm_out); // R9

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0)); // R10

endmodule

bind pwm_sync_channel pwm_sync_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .rdata    (rdata),
    .pwm_out  (pwm_out),
    .pwm_oe   (pwm_oe),
    .pend     (pend),
    .boundary (boundary),
    .act_sel  (act_sel),
    .act_duty (act_duty),
    .restart  (restart),
    .cnt      (cnt),
    .ectl     ({ctl.drive, 1'b0, ctl.oe, 2'b00, ctl.src_pwm, ctl.src_ramp, 1'b0})
);

// File: tb/tb_pwm_sync_channel.sv
module tb_pwm_sync_channel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] ref_tick = 3'b000;
    logic       pwm_out, pwm_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_sync_channel dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ref_tick(ref_tick), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        chk(rdata == exp, req, rdata, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic count_toggles(input int n, output int tg);
        logic prev;
        tg = 0;
        prev = pwm_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out != prev) tg++;
            prev = pwm_out;
        end
    endtask

    task automatic wait_rise(output int n);
        logic prev;
        n = 0;
        prev = pwm_out;
        while (n < 40000) begin
            @(negedge clk);
            n++;
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    task automatic set_duty(input int d);
        wr(pwm_sync_pkg::A_DUTY_LO, d[7:0]);
        wr(pwm_sync_pkg::A_DUTY_HI, d[15:8]);
    endtask

    task automatic sync();
        wr(pwm_sync_pkg::A_SYNC, 8'h01);
    endtask

    task automatic t_reset();
        rd_chk(pwm_sync_pkg::A_SIZE, 8'h00, "R1 size reg");
        rd_chk(pwm_sync_pkg::A_ECTL, 8'h00, "R1 enable reg");
        chk(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
        chk(pwm_oe == 1'b0, "R1 pwm_oe", pwm_oe, 0);
    endtask

    task automatic t_readback();
        wr(pwm_sync_pkg::A_TCFG, 8'h5A);
        rd_chk(pwm_sync_pkg::A_TCFG, 8'h5A, "R2 tcfg readback");
        wr(pwm_sync_pkg::A_PDIV, 8'h63);
        rd_chk(pwm_sync_pkg::A_PDIV, 8'h63, "R2 pdiv readback");
        rd_chk(pwm_sync_pkg::A_SUBTYPE, 8'h0B, "R2 subtype");
        sync();
        rd_chk(pwm_sync_pkg::A_SYNC, 8'h00, "R2 sync reads zero");
        rd_chk(8'h10, 8'h00, "R2 unmapped");
        wr(pwm_sync_pkg::A_TCFG, 8'h00);
        wr(pwm_sync_pkg::A_PDIV, 8'h00);
    endtask

    task automatic t_duty();
        int hi;
        int dl[6] = '{0, 1, 100, 511, 512, 65535};
        ref_tick = 3'b100;
        wr(pwm_sync_pkg::A_SIZE, 8'h07);
        wr(pwm_sync_pkg::A_PDIV, 8'h00);
        wr(pwm_sync_pkg::A_ECTL, 8'hA4);
        for (int k = 0; k < 6; k++) begin
            set_duty(dl[k]);
            sync();
            wait_n(4);
            count_high(512, hi);
            chk(hi == ((dl[k] > 512) ? 512 : dl[k]), "R4 high ticks per period", hi,
                (dl[k] > 512) ? 512 : dl[k]);
        end
    endtask

    task automatic t_shadow();
        int hi;
        set_duty(100);
        sync();
        wait_n(4);
        set_duty(300);
        wait_n(4);
        count_high(512, hi);
        chk(hi == 100, "R3 duty unsynced no effect", hi, 100);
        sync();
        wait_n(4);
        count_high(512, hi);
        chk(hi == 300, "R3 duty after sync", hi, 300);
    endtask

    task automatic t_gate();
        int hi;
        wr(pwm_sync_pkg::A_ECTL, 8'h84);
        wait_n(2);
        count_high(512, hi);
        chk(hi == 300, "R9 drive+src high count", hi, 300);
        chk(pwm_oe == 1'b0, "R9 oe off", pwm_oe, 0);
        wr(pwm_sync_pkg::A_ECTL, 8'h20);
        wait_n(2);
        count_high(512, hi);
        chk(hi == 0, "R9 drive clear low", hi, 0);
        chk(pwm_oe == 1'b1, "R9 oe follows bit5", pwm_oe, 1);
        wr(pwm_sync_pkg::A_ECTL, 8'hA2);
        wait_n(2);
        count_high(512, hi);
        chk(hi == 0, "R9 ramp source only low", hi, 0);
        wr(pwm_sync_pkg::A_ECTL, 8'hA4);
    endtask

    task automatic t_prescale();
        int n;
        int code[4] = '{1, 2, 3, 0};
        int ex[4]   = '{1, 0, 2, 3};
        int ratio[4] = '{1, 3, 5, 6};
        set_duty(256);
        for (int k = 0; k < 4; k++) begin
            wr(pwm_sync_pkg::A_PDIV, 8'((code[k] << 5) | ex[k]));
            sync();
            wait_rise(n);
            wait_rise(n);
            chk(n == 512 * ratio[code[k]] * (1 << ex[k]), "R5 period length", n,
                512 * ratio[code[k]] * (1 << ex[k]));
        end
    endtask

    task automatic t_restart();
        int n;
        wr(pwm_sync_pkg::A_PDIV, 8'h00);
        sync();
        wait_rise(n);
        wait_n(300);
        chk(pwm_out == 1'b0, "R10 precondition low", pwm_out, 0);
        wr(pwm_sync_pkg::A_PDIV, 8'h01);
        sync();
        wait_n(1);
        chk(pwm_out == 1'b1, "R10 restart to count 0", pwm_out, 1);
    endtask

    task automatic t_select();
        int hi, tg;
        ref_tick = 3'b001;
        wr(pwm_sync_pkg::A_SIZE, 8'h05);
        wr(pwm_sync_pkg::A_PDIV, 8'h00);
        sync();
        wait_n(10);
        count_high(512, hi);
        chk(hi == 256, "R6 select 1 uses ref_tick[0]", hi, 256);
        wr(pwm_sync_pkg::A_SIZE, 8'h06);
        sync();
        wait_n(4);
        count_toggles(1500, tg);
        chk(tg == 0, "R6 select 2 with idle ref_tick[1]", tg, 0);
        ref_tick = 3'b111;
        wr(pwm_sync_pkg::A_SIZE, 8'h04);
        sync();
        wait_n(4);
        count_toggles(1500, tg);
        chk(tg == 0, "R6 select 0 static", tg, 0);
    endtask

    task automatic t_idle_pending();
        wr(pwm_sync_pkg::A_TCFG, 8'h20);
        set_duty(0);
        sync();
        wait_n(1);
        chk(pwm_out == 1'b0, "R8 idle commit duty 0", pwm_out, 0);
        set_duty(512);
        sync();
        wait_n(1);
        chk(pwm_out == 1'b1, "R8 idle commit duty 512", pwm_out, 1);
        wr(pwm_sync_pkg::A_TCFG, 8'h00);
    endtask

    task automatic t_glitch();
        int n;
        ref_tick = 3'b100;
        wr(pwm_sync_pkg::A_SIZE, 8'h07);
        wr(pwm_sync_pkg::A_PDIV, 8'h00);
        set_duty(1);
        sync();
        wr(pwm_sync_pkg::A_TCFG, 8'h20);
        wait_rise(n);
        wait_n(100);
        set_duty(512);
        sync();
        wait_n(297);
        chk(pwm_out == 1'b0, "R7 deferred commit holds old duty", pwm_out, 0);
        wait_n(120);
        chk(pwm_out == 1'b1, "R7 commit at period wrap", pwm_out, 1);
        wr(pwm_sync_pkg::A_TCFG, 8'h00);
        set_duty(1);
        sync();
        wait_rise(n);
        wait_n(100);
        set_duty(512);
        sync();
        wait_n(2);
        chk(pwm_out == 1'b1, "R7 immediate commit without glitch bit", pwm_out, 1);
    endtask

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(2);
        t_reset();
        t_readback();
        t_duty();
        t_shadow();
        t_gate();
        t_prescale();
        t_restart();
        t_select();
        t_idle_pending();
        t_glitch();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule